// File: doc/BRIEF.md
# VLAN Membership Table with Command Sequencer

This block keeps the VLAN membership table of a small Ethernet switch. Host software reaches it through five 16-bit registers: an operation register, a VID register and three port data registers. A command runs in the background after software writes the operation register with the busy bit set. Software then polls the busy bit before it issues anything else. The commands are load/purge, get-next, flush-all and get-and-clear-violation.

Each of the 16 table entries holds a valid flag, a 13-bit VID, a 2-bit member tag for each of 12 ports, and an 8-bit database number. Load and get-next search the table linearly, one entry per clock. Flush clears one entry per clock.

The switch datapath uses a separate lookup port. It presents an ingress VID and a source port, and reads back a hit flag and that port's member tag without waiting. A lookup that is flagged as real traffic and either misses the table or finds the port marked not-member is recorded as a violation. Only the first violation is held, and an interrupt stays high until software reads and clears the record.

Top module: `vlan_table_unit`

## Requirements
- R1: Writing register 0 (operation) with bit 15 set while the unit is idle starts the command held in bits 14:12. The codes are 1 = flush-all, 3 = load/purge, 4 = get-next and 7 = get-and-clear-violation. Bit 15 reads 1 while the command runs and 0 once it has finished.
- R2: Register 1 (VID) holds VID[11:0] in bits 11:0, VID bit 12 in bit 13 and the valid flag in bit 12. After reset every register reads 0 and the interrupt is low.
- R3: A load with the valid flag set stores the VID together with the member tags and the database number. Port p's tag comes from data register 2+p/4, at bits 4*(p%4)+1 down to 4*(p%4). The database number comes from operation bits 11:8 (high nibble) and bits 3:0 (low nibble). A load to a VID that is already present overwrites that entry.
- R4: A load with the valid flag clear purges the entry holding that VID. If no such entry exists, the table is unchanged.
- R5: Get-next finds the lowest valid VID strictly greater than the VID register. If the register holds 0x1FFF (all ones), it finds the lowest valid VID. On success it sets the VID register to that VID with valid = 1, loads the entry's tags into the data registers and writes the database number into the operation fields. Repeating get-next continues the walk.
- R6: When no higher valid VID exists, get-next clears the valid flag of the VID register.
- R7: A load of a new VID while all 16 entries are valid stores nothing and sets operation bit 7. This flag is sticky and is cleared only by flush-all.
- R8: Flush-all invalidates every entry and clears the full flag.
- R9: The lookup port raises lk_hit when lk_vid matches a valid entry, and lk_tag gives that entry's tag for lk_port. A port number of 12 or above returns 2'b11 (not member).
- R10: A lookup with lk_valid high records a miss violation if the VID has no entry, or a member violation if the tag is 2'b11. Only the first violation is held. irq is high while a record is pending.
- R11: Get-and-clear-violation writes the source port to operation bits 3:0. It sets bit 6 for a member violation or bit 5 for a miss. It writes the offending VID to the VID register with valid = 0, then clears the record, which drops irq. With nothing pending, bits 6 and 5 read 0.
- R12: Register writes are ignored while a command is running.
- R13: The state bits of the data registers (bits 4*(p%4)+3 down to 4*(p%4)+2) are not stored in the table, and get-next returns them as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 operation, 1 VID, 2..4 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| lk_valid | input | 1 | Lookup is real traffic; enables violation capture |
| lk_vid | input | 13 | Lookup VID |
| lk_port | input | 4 | Lookup source port |
| lk_hit | output | 1 | Lookup VID is present in the table |
| lk_tag | output | 2 | Member tag of lk_port in the matching entry |
| irq | output | 1 | A violation record is pending |

## Verification
A corrupted valid flag or VID in the table shows up on lk_hit in the same cycle, and in the VID sequence of a full get-next walk once the command finishes. That is at most 18 cycles after the command starts. A wrong tag or database number appears in the data or operation registers as soon as get-next returns that entry. A scan index or free-slot error shows up as a missing entry or a spurious full flag on the next load. A broken violation latch changes the port, flags and VID that get-and-clear returns, and the cycle in which irq falls.

// File: rtl/vlan_pkg.sv
package vlan_pkg;
  localparam int VID_W = 13;
  localparam int FID_W = 8;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FLUSH = 3'd1,
    OP_LOAD  = 3'd3,
    OP_NEXT  = 3'd4,
    OP_VIOL  = 3'd7
  } vop_e;

  localparam logic [2:0] A_OP   = 3'd0;
  localparam logic [2:0] A_VID  = 3'd1;
  localparam logic [2:0] A_DAT0 = 3'd2;

  // VID register image: bit 13 = VID[12], bit 12 = valid, 11:0 = VID[11:0]
  function automatic logic [15:0] vidreg_image(input logic [VID_W-1:0] v, input logic val);
    return {2'b00, v[12], val, v[11:0]};
  endfunction

  function automatic logic [FID_W-1:0] fid_from_fields(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/vlan_entry_store.sv
module vlan_entry_store
  import vlan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  logic                      wr_valid,
  input  logic [VID_W-1:0]          wr_vid,
  input  logic [2*NPORTS-1:0]       wr_tags,
  input  logic [FID_W-1:0]          wr_fid,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic                      rd_valid,
  output logic [VID_W-1:0]          rd_vid,
  output logic [2*NPORTS-1:0]       rd_tags,
  output logic [FID_W-1:0]          rd_fid,
  input  logic [VID_W-1:0]          lk_vid,
  input  logic [$clog2(NPORTS)-1:0] lk_port,
  output logic                      lk_hit,
  output logic [1:0]                lk_tag,
  output logic [DEPTH-1:0]          valid_vec
);
  localparam int TAG_W = 2 * NPORTS;

  logic [VID_W-1:0] ent_vid  [DEPTH];
  logic [TAG_W-1:0] ent_tags [DEPTH];
  logic [FID_W-1:0] ent_fid  [DEPTH];
  logic [DEPTH-1:0] match_vec;
  logic [TAG_W-1:0] hit_tags;
  logic [TAG_W-1:0] hit_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_vec <= '0;
    else if (wr_en) valid_vec[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      ent_vid[wr_idx]  <= wr_vid;
      ent_tags[wr_idx] <= wr_tags;
      ent_fid[wr_idx]  <= wr_fid;
    end
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_vid   = ent_vid[rd_idx];
  assign rd_tags  = ent_tags[rd_idx];
  assign rd_fid   = ent_fid[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (ent_vid[g] == lk_vid);
  end

  always_comb begin
    lk_hit   = 1'b0;
    hit_tags = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        lk_hit   = 1'b1;
        hit_tags = ent_tags[i];
      end
    end
  end

  assign hit_shift = hit_tags >> {lk_port, 1'b0};
  assign lk_tag    = (int'(lk_port) < NPORTS) ? hit_shift[1:0] : 2'b11;
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vlan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               start_op,
  input  logic [VID_W-1:0]         key_vid,
  input  logic                     key_valid,
  input  logic [2*NPORTS-1:0]      key_tags,
  input  logic [FID_W-1:0]         key_fid,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  input  logic                     rd_valid,
  input  logic [VID_W-1:0]         rd_vid,
  input  logic [2*NPORTS-1:0]      rd_tags,
  input  logic [FID_W-1:0]         rd_fid,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic                     wr_valid,
  output logic [VID_W-1:0]         wr_vid,
  output logic [2*NPORTS-1:0]      wr_tags,
  output logic [FID_W-1:0]         wr_fid,
  output logic                     busy,
  output logic                     done,
  output logic [2:0]               done_op,
  output logic                     full_set,
  output logic                     res_found,
  output logic [VID_W-1:0]         res_vid,
  output logic [2*NPORTS-1:0]      res_tags,
  output logic [FID_W-1:0]         res_fid
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = 2 * NPORTS;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} st_e;

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic [2:0]       op_q;
  logic [VID_W-1:0] key_vid_q;
  logic             key_valid_q;
  logic [TAG_W-1:0] key_tags_q;
  logic [FID_W-1:0] key_fid_q;
  logic             free_seen;
  logic [IDX_W-1:0] free_idx;
  logic             best_found;
  logic [VID_W-1:0] best_vid;
  logic [TAG_W-1:0] best_tags;
  logic [FID_W-1:0] best_fid;

  logic last, hit_key, wrap, cand, free_any, scan_end, scanning;
  logic [IDX_W-1:0] free_pick;

  assign scanning  = (st == S_SCAN);
  assign last      = (idx == LAST);
  assign hit_key   = rd_valid && (rd_vid == key_vid_q);
  assign wrap      = (key_vid_q == '1);
  assign cand      = rd_valid && (wrap || rd_vid > key_vid_q) &&
                     (!best_found || rd_vid < best_vid);
  assign free_any  = free_seen || !rd_valid;
  assign free_pick = free_seen ? free_idx : idx;
  assign scan_end  = last || (op_q == OP_LOAD && hit_key);

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = idx;
    wr_valid = key_valid_q;
    wr_vid   = key_vid_q;
    wr_tags  = key_tags_q;
    wr_fid   = key_fid_q;
    full_set = 1'b0;
    if (scanning) begin
      if (op_q == OP_FLUSH) begin
        wr_en    = 1'b1;
        wr_valid = 1'b0;
      end else if (op_q == OP_LOAD) begin
        if (hit_key) begin
          wr_en = 1'b1;
        end else if (last && key_valid_q) begin
          if (free_any) begin
            wr_en  = 1'b1;
            wr_idx = free_pick;
          end else begin
            full_set = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      idx         <= '0;
      op_q        <= OP_NONE;
      key_vid_q   <= '0;
      key_valid_q <= 1'b0;
      key_tags_q  <= '0;
      key_fid_q   <= '0;
      free_seen   <= 1'b0;
      free_idx    <= '0;
      best_found  <= 1'b0;
      best_vid    <= '0;
      best_tags   <= '0;
      best_fid    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q        <= start_op;
          key_vid_q   <= key_vid;
          key_valid_q <= key_valid;
          key_tags_q  <= key_tags;
          key_fid_q   <= key_fid;
          idx         <= '0;
          free_seen   <= 1'b0;
          best_found  <= 1'b0;
          st <= (start_op == OP_FLUSH || start_op == OP_LOAD || start_op == OP_NEXT)
                ? S_SCAN : S_DONE;
        end
        S_SCAN: begin
          if (op_q == OP_NEXT && cand) begin
            best_found <= 1'b1;
            best_vid   <= rd_vid;
            best_tags  <= rd_tags;
            best_fid   <= rd_fid;
          end
          if (op_q == OP_LOAD && !rd_valid && !free_seen) begin
            free_seen <= 1'b1;
            free_idx  <= idx;
          end
          if (scan_end) st <= S_DONE;
          else          idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_idx    = idx;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign done_op   = op_q;
  assign res_found = best_found;
  assign res_vid   = best_vid;
  assign res_tags  = best_tags;
  assign res_fid   = best_fid;
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vlan_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VID_W-1:0]  lk_vid,
  input  logic [PORT_W-1:0] lk_port,
  input  logic              lk_hit,
  input  logic [1:0]        lk_tag,
  input  logic              clear,
  output logic              pend,
  output logic              rec_member,
  output logic [PORT_W-1:0] rec_port,
  output logic [VID_W-1:0]  rec_vid,
  output logic              viol_event,
  output logic              capture
);
  assign viol_event = lk_valid && (!lk_hit || lk_tag == 2'b11);
  // a new violation in the clearing cycle is kept, since the old one is being read out
  assign capture    = viol_event && (!pend || clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      rec_member <= 1'b0;
      rec_port   <= '0;
      rec_vid    <= '0;
    end else if (capture) begin
      pend       <= 1'b1;
      rec_member <= lk_hit;
      rec_port   <= lk_port;
      rec_vid    <= lk_vid;
    end else if (clear) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/vlan_table_unit.sv
module vlan_table_unit
  import vlan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [2:0]                reg_addr,
  input  logic [15:0]               reg_wdata,
  output logic [15:0]               reg_rdata,
  input  logic                      lk_valid,
  input  logic [VID_W-1:0]          lk_vid,
  input  logic [$clog2(NPORTS)-1:0] lk_port,
  output logic                      lk_hit,
  output logic [1:0]                lk_tag,
  output logic                      irq
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int TAG_W  = 2 * NPORTS;
  localparam int NDATA  = (NPORTS + 3) / 4;

  function automatic logic [TAG_W-1:0] tags_of(input logic [NDATA*16-1:0] d);
    tags_of = '0;
    for (int p = 0; p < NPORTS; p++) tags_of[2*p +: 2] = d[16*(p/4) + 4*(p%4) +: 2];
  endfunction

  function automatic logic [NDATA*16-1:0] data_of(input logic [TAG_W-1:0] t);
    data_of = '0;
    for (int p = 0; p < NPORTS; p++) data_of[16*(p/4) + 4*(p%4) +: 2] = t[2*p +: 2];
  endfunction

  logic [2:0]         op_code;
  logic [3:0]         fid_hi, low_nib;
  logic               flag_mem, flag_miss, full_q;
  logic [VID_W-1:0]   vid_q;
  logic               vval_q;
  logic [NDATA*16-1:0] data_q;

  logic               busy, cmd_done, full_set, start, host_ok, viol_clear;
  logic [2:0]         cmd_done_op;
  logic [IDX_W-1:0]   rd_idx, wr_idx;
  logic               rd_valid, wr_en, wr_valid;
  logic [VID_W-1:0]   rd_vid, wr_vid, res_vid;
  logic [TAG_W-1:0]   rd_tags, wr_tags, res_tags;
  logic [FID_W-1:0]   rd_fid, wr_fid, res_fid;
  logic               res_found;
  logic [DEPTH-1:0]   ent_valid_vec;
  logic               pend, rec_member, viol_event, viol_capture;
  logic [PORT_W-1:0]  rec_port;
  logic [VID_W-1:0]   rec_vid;

  assign host_ok    = reg_wr && !busy;
  assign start      = host_ok && reg_addr == A_OP && reg_wdata[15];
  assign viol_clear = cmd_done && cmd_done_op == OP_VIOL;

  vlan_entry_store #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vid(wr_vid),
    .wr_tags(wr_tags), .wr_fid(wr_fid),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vid(rd_vid), .rd_tags(rd_tags), .rd_fid(rd_fid),
    .lk_vid(lk_vid), .lk_port(lk_port), .lk_hit(lk_hit), .lk_tag(lk_tag),
    .valid_vec(ent_valid_vec)
  );

  vlan_cmd_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_op(reg_wdata[14:12]),
    .key_vid(vid_q), .key_valid(vval_q), .key_tags(tags_of(data_q)),
    .key_fid(fid_from_fields(reg_wdata[11:8], reg_wdata[3:0])),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vid(rd_vid), .rd_tags(rd_tags), .rd_fid(rd_fid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vid(wr_vid),
    .wr_tags(wr_tags), .wr_fid(wr_fid),
    .busy(busy), .done(cmd_done), .done_op(cmd_done_op), .full_set(full_set),
    .res_found(res_found), .res_vid(res_vid), .res_tags(res_tags), .res_fid(res_fid)
  );

  vlan_viol_capture #(.PORT_W(PORT_W)) u_viol (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vid(lk_vid), .lk_port(lk_port),
    .lk_hit(lk_hit), .lk_tag(lk_tag), .clear(viol_clear),
    .pend(pend), .rec_member(rec_member), .rec_port(rec_port), .rec_vid(rec_vid),
    .viol_event(viol_event), .capture(viol_capture)
  );

  assign irq = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_code   <= '0;
      fid_hi    <= '0;
      low_nib   <= '0;
      flag_mem  <= 1'b0;
      flag_miss <= 1'b0;
      full_q    <= 1'b0;
      vid_q     <= '0;
      vval_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      if (host_ok) begin
        if (reg_addr == A_OP) begin
          op_code   <= reg_wdata[14:12];
          fid_hi    <= reg_wdata[11:8];
          low_nib   <= reg_wdata[3:0];
          flag_mem  <= 1'b0;
          flag_miss <= 1'b0;
        end
        if (reg_addr == A_VID) begin
          vid_q  <= {reg_wdata[13], reg_wdata[11:0]};
          vval_q <= reg_wdata[12];
        end
        for (int r = 0; r < NDATA; r++)
          if (reg_addr == 3'(r + 2)) data_q[16*r +: 16] <= reg_wdata;
      end
      if (full_set) full_q <= 1'b1;
      if (cmd_done) begin
        case (cmd_done_op)
          OP_FLUSH: full_q <= 1'b0;
          OP_NEXT: begin
            if (res_found) begin
              vid_q   <= res_vid;
              vval_q  <= 1'b1;
              data_q  <= data_of(res_tags);
              fid_hi  <= res_fid[7:4];
              low_nib <= res_fid[3:0];
            end else begin
              vval_q <= 1'b0;
            end
          end
          OP_VIOL: begin
            flag_mem  <= pend && rec_member;
            flag_miss <= pend && !rec_member;
            if (pend) begin
              low_nib <= 4'(rec_port);
              vid_q   <= rec_vid;
              vval_q  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_OP)
      reg_rdata = {busy, op_code, fid_hi, full_q, flag_mem, flag_miss, 1'b0, low_nib};
    else if (reg_addr == A_VID)
      reg_rdata = vidreg_image(vid_q, vval_q);
    for (int r = 0; r < NDATA; r++)
      if (reg_addr == 3'(r + 2)) reg_rdata = data_q[16*r +: 16];
  end
endmodule

// File: rtl/vlan_table_unit_chk.sv
module vlan_table_unit_chk
  import vlan_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             busy,
  input logic             cmd_done,
  input logic [2:0]       cmd_done_op,
  input logic [VID_W-1:0] vid_q,
  input logic             vval_q,
  input logic             full_q,
  input logic             irq,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             viol_clear,
  input logic [DEPTH-1:0] ent_valid_vec
);
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OP && reg_wdata[15] && !busy) |=> busy);

  a_r1_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !busy);

  a_r12_busy_blocks_vid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_done && reg_wr && reg_addr == A_VID) |=> ($stable(vid_q) && $stable(vval_q)));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_done_op == OP_FLUSH) |=> (ent_valid_vec == '0));

  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(cmd_done && cmd_done_op == OP_FLUSH));

  a_r10_miss_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |=> irq);

  a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(lk_valid));

  a_r11_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(viol_clear));
endmodule

bind vlan_table_unit vlan_table_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .cmd_done(cmd_done), .cmd_done_op(cmd_done_op),
  .vid_q(vid_q), .vval_q(vval_q), .full_q(full_q), .irq(irq),
  .lk_valid(lk_valid), .lk_hit(lk_hit), .viol_clear(viol_clear),
  .ent_valid_vec(ent_valid_vec)
);

// File: tb/vlan_table_unit_bench.sv
module vlan_table_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [12:0] lk_vid = '0;
  logic [3:0]  lk_port = '0;
  logic        lk_hit;
  logic [1:0]  lk_tag;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  bit present [17];
  int seedm [17];

  always #10 clk = ~clk;

  vlan_table_unit u_vlan_table_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_vid(lk_vid), .lk_port(lk_port),
    .lk_hit(lk_hit), .lk_tag(lk_tag), .irq(irq)
  );

  function automatic logic [12:0] vidk(input int k);
    return 13'((k * 613 + 7) % 8192);
  endfunction
  function automatic logic [1:0] tagf(input logic [12:0] v, input int p, input int s);
    return 2'(((int'(v) >> 1) ^ (p * 5) ^ s) & 3);
  endfunction
  function automatic logic [7:0] fidf(input logic [12:0] v, input int s);
    return 8'((int'(v) * 7 + s) & 255);
  endfunction
  function automatic logic [15:0] vreg(input logic [12:0] v, input logic val);
    return {2'b00, v[12], val, v[11:0]};
  endfunction
  function automatic logic [15:0] dreg(input logic [12:0] v, input int s, input int r, input logic [1:0] st);
    logic [15:0] d = '0;
    for (int i = 0; i < 4; i++) d[4*i +: 4] = {st, tagf(v, 4*r + i, s)};
    return d;
  endfunction
  function automatic int next_k(input logic [12:0] key);
    int b = -1;
    for (int k = 0; k < 17; k++)
      if (present[k] && (key == 13'h1FFF || vidk(k) > key) && (b < 0 || vidk(k) < vidk(b))) b = k;
    return b;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(3'd0, v);
      if (!v[15]) return;
    end
    check("R1 busy timeout", 16'h1, 16'h0);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] fid);
    wr(3'd0, {1'b1, op, fid[7:4], 4'h0, fid[3:0]});
    wait_idle();
  endtask

  task automatic load_k(input int k, input int s, input logic val);
    wr(3'd1, vreg(vidk(k), val));
    for (int r = 0; r < 3; r++) wr(3'(r + 2), dreg(vidk(k), s, r, 2'b10));
    cmd(3'd3, fidf(vidk(k), s));
  endtask

  task automatic walk(input logic [12:0] start);
    logic [15:0] v;
    logic [12:0] key;
    int e;
    key = start;
    wr(3'd1, vreg(start, 1'b0));
    for (int it = 0; it < 20; it++) begin
      cmd(3'd4, 8'h00);
      e = next_k(key);
      rd(3'd1, v);
      if (e < 0) begin
        check("R6 walk end valid", 16'(v[12]), 16'h0);
        break;
      end
      check("R5 next vid", v, vreg(vidk(e), 1'b1));
      for (int r = 0; r < 3; r++) begin
        rd(3'(r + 2), v);
        check("R13 R3 tags", v, dreg(vidk(e), seedm[e], r, 2'b00));
      end
      rd(3'd0, v);
      check("R3 fid", {8'h0, v[11:8], v[3:0]}, {8'h0, fidf(vidk(e), seedm[e])});
      key = vidk(e);
    end
  endtask

  task automatic look(input logic [12:0] v, input int p, output logic h, output logic [1:0] t);
    @(negedge clk); lk_valid = 1'b0; lk_vid = v; lk_port = 4'(p); #2 h = lk_hit; t = lk_tag;
  endtask

  task automatic pulse(input logic [12:0] v, input int p);
    @(negedge clk); lk_valid = 1'b1; lk_vid = v; lk_port = 4'(p);
    @(negedge clk); lk_valid = 1'b0; #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic h;
    logic [1:0] t;
    int mk, mp;
    for (int k = 0; k < 17; k++) begin present[k] = 0; seedm[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(3'd0, v); check("R2 reset op", v, 16'h0);
    rd(3'd1, v); check("R2 reset vid", v, 16'h0);
    rd(3'd2, v); check("R2 reset data", v, 16'h0);
    check("R2 reset irq", 16'(irq), 16'h0);
    look(13'd7, 0, h, t); check("R9 empty miss", 16'(h), 16'h0);

    // R3 loads and R5/R6 full walk, including the strict-greater start
    for (int k = 0; k < 12; k++) begin load_k(k, 0, 1'b1); present[k] = 1; end
    walk(13'h1FFF);
    walk(vidk(3));
    rd(3'd0, v); check("R1 op idle", 16'(v[15]), 16'h0);

    // R3 overwrite
    load_k(4, 9, 1'b1); seedm[4] = 9;
    walk(vidk(4) - 13'd1);
    walk(13'h1FFF);

    // R4 purge existing and absent
    load_k(6, 0, 1'b0); present[6] = 0;
    load_k(14, 0, 1'b0);
    walk(13'h1FFF);

    // R9 lookup sweep
    for (int k = 0; k < 17; k++) begin
      for (int p = 0; p < 14; p++) begin
        look(vidk(k), p, h, t);
        check("R9 hit", 16'(h), 16'(present[k]));
        if (present[k]) check("R9 tag", 16'(t), (p < 12) ? 16'(tagf(vidk(k), p, seedm[k])) : 16'h3);
      end
    end
    check("R10 no capture idle", 16'(irq), 16'h0);

    // R7 table full
    load_k(6, 0, 1'b1); present[6] = 1;
    for (int k = 12; k < 16; k++) begin load_k(k, 0, 1'b1); present[k] = 1; end
    rd(3'd0, v); check("R7 not full at 16", 16'(v[7]), 16'h0);
    load_k(16, 0, 1'b1);
    rd(3'd0, v); check("R7 full set", 16'(v[7]), 16'h1);
    look(vidk(16), 0, h, t); check("R7 not stored", 16'(h), 16'h0);
    load_k(15, 0, 1'b0); present[15] = 0;
    rd(3'd0, v); check("R7 full sticky", 16'(v[7]), 16'h1);
    walk(13'h1FFF);

    // R10 / R11 violations
    mk = -1; mp = 0;
    for (int k = 0; k < 15; k++)
      for (int p = 0; p < 12; p++)
        if (mk < 0 && present[k] && tagf(vidk(k), p, seedm[k]) == 2'b11) begin mk = k; mp = p; end
    for (int p = 0; p < 12; p++)
      if (tagf(vidk(0), p, seedm[0]) != 2'b11) begin
        pulse(vidk(0), p);
        check("R10 member ok no irq", 16'(irq), 16'h0);
        break;
      end
    pulse(13'd2, 5);
    check("R10 miss irq", 16'(irq), 16'h1);
    pulse(vidk(mk), mp);
    check("R10 irq held", 16'(irq), 16'h1);
    cmd(3'd7, 8'h00);
    rd(3'd0, v);
    check("R11 miss port", 16'(v[3:0]), 16'd5);
    check("R11 miss flags", 16'(v[6:5]), 16'b01);
    rd(3'd1, v); check("R11 miss vid", v, vreg(13'd2, 1'b0));
    check("R11 irq cleared", 16'(irq), 16'h0);
    pulse(vidk(mk), mp);
    check("R10 member irq", 16'(irq), 16'h1);
    cmd(3'd7, 8'h00);
    rd(3'd0, v);
    check("R11 member port", 16'(v[3:0]), 16'(mp));
    check("R11 member flags", 16'(v[6:5]), 16'b10);
    rd(3'd1, v); check("R11 member vid", v, vreg(vidk(mk), 1'b0));
    cmd(3'd7, 8'h00);
    rd(3'd0, v); check("R11 empty flags", 16'(v[6:5]), 16'b00);

    // R12 writes ignored while busy, R1 busy visible, R8 flush
    wr(3'd1, vreg(13'h0ABC, 1'b0));
    wr(3'd0, 16'h9000);
    rd(3'd0, v); check("R1 busy seen", 16'(v[15]), 16'h1);
    wr(3'd1, vreg(13'h0123, 1'b1));
    wr(3'd2, 16'hFFFF);
    wait_idle();
    rd(3'd1, v); check("R12 vid kept", v, vreg(13'h0ABC, 1'b0));
    rd(3'd0, v); check("R8 full cleared", 16'(v[7]), 16'h0);
    for (int k = 0; k < 17; k++) present[k] = 0;
    for (int k = 0; k < 16; k++) begin
      look(vidk(k), 0, h, t); check("R8 flushed", 16'(h), 16'h0);
    end
    walk(13'h1FFF);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule